// File: doc/BRIEF.md
# Capture/Reload Interval Timer

This block is a 16-bit up-counter with a companion 16-bit holding register and an external trigger pin. It counts either single cycles qualified by an internal tick enable, or falling edges seen on an external count pin. One control byte selects how the holding register is used. In auto-reload mode, the counter restarts from the holding value when it overflows. In capture mode, the counter wraps to zero on overflow, and a trigger edge copies the running count into the holding register.

An overflow flag and a trigger-event flag combine into a single interrupt request. Both flags stay set until software rewrites the control byte. Two clock-select bits are only stored and driven out, for a serial-port baud generator that sits outside this block.

All registers sit behind a byte-wide bus. Writes are synchronous and reads are combinational. Both pins pass through a synchronizer before their falling edges are detected.

Top module: `tmr16_cr`

## Requirements
- R1: After synchronous reset the control byte, both counter bytes and both holding bytes read 00h, and `irq`, `rxclk_sel` and `txclk_sel` are low.
- R2: Bus map: address 0 is the control byte, addresses 1/2 are the counter low/high bytes, addresses 3/4 are the holding register low/high bytes, and any other address reads 00h. Written values read back unchanged. Control bits: bit0 capture select (1 = capture, 0 = reload), bit1 count-source select (1 = count pin), bit2 run, bit3 trigger enable, bit4 transmit clock select, bit5 receive clock select, bit6 trigger-event flag, bit7 overflow flag.
- R3: While run is 0 the counter does not advance, whatever the tick enable or count pin does.
- R4: With run = 1 and count-source select = 0, the counter advances by one on each clock in which `tick_en` is high.
- R5: With run = 1 and count-source select = 1, the counter advances by one for each falling edge on `cnt_pin`. Rising edges and `tick_en` have no effect.
- R6: In reload mode, an increment from FFFFh loads the holding value into the counter and sets the overflow flag.
- R7: In capture mode, an increment from FFFFh wraps the counter to 0000h, sets the overflow flag and leaves the holding register unchanged.
- R8: With trigger enable = 0, falling edges on `trig_pin` change neither the holding register, the counter nor the event flag.
- R9: With trigger enable = 1 in capture mode, a falling edge on `trig_pin` copies the counter into the holding register and sets the event flag. This works even while run is 0.
- R10: With trigger enable = 1 in reload mode, a falling edge on `trig_pin` loads the holding value into the counter and sets the event flag.
- R11: Each flag stays set until the control byte is written. `irq` is high exactly while either flag is set.
- R12: Control bits 5 and 4 are driven unchanged on `rxclk_sel` and `txclk_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Internal count enable (timer mode) |
| cnt_pin | input | 1 | External count pin, asynchronous |
| trig_pin | input | 1 | External capture/reload trigger, asynchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Combined flag interrupt request |
| rxclk_sel | output | 1 | Stored receive clock select |
| txclk_sel | output | 1 | Stored transmit clock select |

## Verification
The assertions check the following on every cycle:
- the counter holding still while stopped;
- the reload or wrap that follows an overflow increment, together with the overflow flag;
- the holding register and event flag staying put while triggers are disabled;
- both flags remaining set until the control byte is written.

Only the bench scenarios can show the things that depend on a whole sequence of inputs: the exact count after a run of ticks or pin edges, the synchronizer latency before a pin edge acts, the value captured by a trigger, and the read-back of the bus map and clock-select outputs.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    // Control byte, bit7 down to bit0
    typedef struct packed {
        logic ovf;      // bit7 overflow flag
        logic ev;       // bit6 trigger-event flag
        logic rxclk;    // bit5 receive clock select
        logic txclk;    // bit4 transmit clock select
        logic trig_en;  // bit3 trigger enable
        logic run;      // bit2 run control
        logic ext_cnt;  // bit1 count pin as source
        logic capture;  // bit0 capture (1) / reload (0)
    } tmr_ctrl_t;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_STEP,
        ACT_WRAP,
        ACT_LOAD
    } cnt_act_e;

    // Counter action for this cycle; a trigger reload wins over stepping.
    function automatic cnt_act_e pick_act(input logic capture, input logic step,
                                          input logic at_max, input logic trig_reload);
        if (trig_reload)
            return ACT_LOAD;
        if (step && at_max)
            return capture ? ACT_WRAP : ACT_LOAD;
        if (step)
            return ACT_STEP;
        return ACT_HOLD;
    endfunction

endpackage

// File: rtl/tmr16_edge.sv
module tmr16_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Idle level is high so reset creates no false edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
    import tmr16_pkg::*;
#(
    parameter  int CNT_W = 16,
    localparam int NB    = CNT_W / 8
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_ctrl_t        ctrl,
    input  logic             tick_en,
    input  logic             cnt_fall,
    input  logic             trig_fall,
    input  logic [NB-1:0]    cnt_wr_en,
    input  logic [NB-1:0]    rld_wr_en,
    input  logic [7:0]       wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] rld_q,
    output logic             ovf_set,
    output logic             ev_set
);
    logic             step;
    logic             trig_hit;
    logic             at_max;
    cnt_act_e         act;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] rld_nxt;

    always_comb begin
        step     = ctrl.run && (ctrl.ext_cnt ? cnt_fall : tick_en);
        trig_hit = ctrl.trig_en && trig_fall;
        at_max   = &cnt_q;
        act      = pick_act(ctrl.capture, step, at_max, trig_hit && !ctrl.capture);

        unique case (act)
            ACT_STEP: cnt_nxt = cnt_q + CNT_W'(1);
            ACT_WRAP: cnt_nxt = '0;
            ACT_LOAD: cnt_nxt = rld_q;
            default:  cnt_nxt = cnt_q;
        endcase

        rld_nxt = rld_q;
        if (trig_hit && ctrl.capture)
            rld_nxt = cnt_q;

        // Bus writes take priority over hardware updates.
        for (int b = 0; b < NB; b++) begin
            if (cnt_wr_en[b]) cnt_nxt[b*8 +: 8] = wdata;
            if (rld_wr_en[b]) rld_nxt[b*8 +: 8] = wdata;
        end

        ovf_set = step && at_max;
        ev_set  = trig_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rld_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            rld_q <= rld_nxt;
        end
    end
endmodule

// File: rtl/tmr16_cr.sv
module tmr16_cr
    import tmr16_pkg::*;
#(
    parameter  int CNT_W       = 16,
    parameter  int SYNC_STAGES = 2,
    localparam int NB          = CNT_W / 8,
    localparam int ADDR_W      = $clog2(2 * NB + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    output logic              rxclk_sel,
    output logic              txclk_sel
);
    localparam int NPINS = 2;   // index 0 count pin, index 1 trigger pin

    tmr_ctrl_t        ctrl_q;
    tmr_ctrl_t        ctrl_nxt;
    logic             ctrl_wr;
    logic [NB-1:0]    cnt_wr_en;
    logic [NB-1:0]    rld_wr_en;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rld_q;
    logic             ovf_set;
    logic             ev_set;
    logic [NPINS-1:0] pins;
    logic [NPINS-1:0] falls;
    logic             cnt_fall;
    logic             trig_fall;

    assign pins = {trig_pin, cnt_pin};

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        tmr16_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst  (rst),
            .pin  (pins[g]),
            .fall (falls[g])
        );
    end

    assign cnt_fall  = falls[0];
    assign trig_fall = falls[1];

    // Write decode
    always_comb begin
        ctrl_wr   = bus_we && (bus_addr == '0);
        cnt_wr_en = '0;
        rld_wr_en = '0;
        for (int b = 0; b < NB; b++) begin
            cnt_wr_en[b] = bus_we && (bus_addr == ADDR_W'(1 + b));
            rld_wr_en[b] = bus_we && (bus_addr == ADDR_W'(1 + NB + b));
        end
    end

    tmr16_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl_q),
        .tick_en   (tick_en),
        .cnt_fall  (cnt_fall),
        .trig_fall (trig_fall),
        .cnt_wr_en (cnt_wr_en),
        .rld_wr_en (rld_wr_en),
        .wdata     (bus_wdata),
        .cnt_q     (cnt_q),
        .rld_q     (rld_q),
        .ovf_set   (ovf_set),
        .ev_set    (ev_set)
    );

    // Control byte; a hardware flag set wins over a same-cycle write.
    always_comb begin
        ctrl_nxt = ctrl_q;
        if (ctrl_wr)
            ctrl_nxt = tmr_ctrl_t'(bus_wdata);
        if (ovf_set)
            ctrl_nxt.ovf = 1'b1;
        if (ev_set)
            ctrl_nxt.ev = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else
            ctrl_q <= ctrl_nxt;
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0)
            bus_rdata = ctrl_q;
        for (int b = 0; b < NB; b++) begin
            if (bus_addr == ADDR_W'(1 + b))
                bus_rdata = cnt_q[b*8 +: 8];
            if (bus_addr == ADDR_W'(1 + NB + b))
                bus_rdata = rld_q[b*8 +: 8];
        end
    end

    assign irq       = ctrl_q.ovf | ctrl_q.ev;
    assign rxclk_sel = ctrl_q.rxclk;
    assign txclk_sel = ctrl_q.txclk;
endmodule

// File: rtl/tmr16_cr_chk.sv
module tmr16_cr_chk
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input tmr_ctrl_t        ctrl_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] rld_q,
    input logic             tick_en,
    input logic             cnt_fall,
    input logic             trig_fall,
    input logic             cnt_wr_any,
    input logic             rld_wr_any,
    input logic             ctrl_wr
);
    logic step_seen;
    assign step_seen = ctrl_q.run && (ctrl_q.ext_cnt ? cnt_fall : tick_en);

    // R3: stopped counter holds unless written or trigger-reloaded
    a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !cnt_wr_any && !(ctrl_q.trig_en && trig_fall && !ctrl_q.capture))
        |=> $stable(cnt_q));

    // R6: reload on overflow
    a_r6_reload_on_ovf: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.capture && step_seen && (&cnt_q) && !cnt_wr_any)
        |=> (cnt_q == $past(rld_q)) && ctrl_q.ovf);

    // R7: wrap on overflow in capture mode
    a_r7_wrap_on_ovf: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.capture && step_seen && (&cnt_q) && !cnt_wr_any)
        |=> (cnt_q == '0) && ctrl_q.ovf);

    // R8: disabled trigger leaves the holding register alone
    a_r8_rld_untouched: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.trig_en && !rld_wr_any) |=> $stable(rld_q));

    // R8: disabled trigger raises no event
    a_r8_no_event: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.trig_en && !ctrl_wr) |=> (ctrl_q.ev == $past(ctrl_q.ev)));

    // R11: flags are sticky until the control byte is written
    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.ovf && !ctrl_wr) |=> ctrl_q.ovf);

    a_r11_ev_sticky: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.ev && !ctrl_wr) |=> ctrl_q.ev);
endmodule

bind tmr16_cr tmr16_cr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_q     (ctrl_q),
    .cnt_q      (cnt_q),
    .rld_q      (rld_q),
    .tick_en    (tick_en),
    .cnt_fall   (cnt_fall),
    .trig_fall  (trig_fall),
    .cnt_wr_any (|cnt_wr_en),
    .rld_wr_any (|rld_wr_en),
    .ctrl_wr    (ctrl_wr)
);

// File: tb/test_tmr16_cr.sv
module test_tmr16_cr;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       cnt_pin = 1'b1;
    logic       trig_pin = 1'b1;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       rxclk_sel;
    logic       txclk_sel;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    tmr16_cr i_tmr16_cr (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .cnt_pin   (cnt_pin),
        .trig_pin  (trig_pin),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .rxclk_sel (rxclk_sel),
        .txclk_sel (txclk_sel)
    );

    // Scoreboard item: kind 0 = bus read, 1 = irq, 2 = {rxclk_sel, txclk_sel}
    typedef struct {
        int         kind;
        logic [2:0] addr;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    event  sample_ev;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Monitor
    initial begin
        forever begin
            @(sample_ev);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = bus_rdata;
                    1:       act = {7'd0, irq};
                    default: act = {6'd0, rxclk_sel, txclk_sel};
                endcase
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_item(input int kind, input logic [2:0] a,
                               input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it.kind = kind; it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        ->sample_ev;
    endtask

    task automatic expect_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        expect_item(0, a, e, tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr16(input logic [2:0] lo_addr, input logic [15:0] v);
        wr(lo_addr, v[7:0]);
        wr(lo_addr + 3'd1, v[15:8]);
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic cnt_pulse();
        @(negedge clk); cnt_pin = 1'b0;
        repeat (4) @(negedge clk); cnt_pin = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic trig_pulse();
        @(negedge clk); trig_pin = 1'b0;
        repeat (4) @(negedge clk); trig_pin = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_rd(3'd0, 8'h00, "R1 ctrl");
        expect_rd(3'd1, 8'h00, "R1 cnt lo");
        expect_rd(3'd2, 8'h00, "R1 cnt hi");
        expect_rd(3'd3, 8'h00, "R1 rld lo");
        expect_rd(3'd4, 8'h00, "R1 rld hi");
        expect_item(1, 3'd0, 8'h00, "R1 irq");
        expect_item(2, 3'd0, 8'h00, "R1 clk selects");

        // R2 read-back and unused address
        wr16(3'd1, 16'h1234);
        wr16(3'd3, 16'hBEEF);
        expect_rd(3'd1, 8'h34, "R2 cnt lo");
        expect_rd(3'd2, 8'h12, "R2 cnt hi");
        expect_rd(3'd3, 8'hEF, "R2 rld lo");
        expect_rd(3'd4, 8'hBE, "R2 rld hi");
        expect_rd(3'd7, 8'h00, "R2 unused address");

        // R3 stopped timer ignores ticks and pin edges
        tick(10);
        cnt_pulse();
        expect_rd(3'd1, 8'h34, "R3 stopped lo");
        expect_rd(3'd2, 8'h12, "R3 stopped hi");

        // R4 timer mode
        wr16(3'd1, 16'h0010);
        wr(3'd0, 8'h04);
        tick(5);
        expect_rd(3'd1, 8'h15, "R4 five ticks");
        expect_rd(3'd2, 8'h00, "R4 hi");

        // R6 reload on overflow
        wr(3'd0, 8'h00);
        wr16(3'd3, 16'hAB00);
        wr16(3'd1, 16'hFFFE);
        wr(3'd0, 8'h04);
        tick(3);
        expect_rd(3'd1, 8'h01, "R6 reload lo");
        expect_rd(3'd2, 8'hAB, "R6 reload hi");
        expect_rd(3'd0, 8'h84, "R6 ovf flag");
        expect_item(1, 3'd0, 8'h01, "R11 irq on ovf");

        // R11 flags clear only by writing control
        tick(2);
        expect_rd(3'd0, 8'h84, "R11 ovf sticky");
        wr(3'd0, 8'h00);
        expect_rd(3'd0, 8'h00, "R11 cleared");
        expect_item(1, 3'd0, 8'h00, "R11 irq low");

        // R7 capture-mode wrap
        wr16(3'd3, 16'h5555);
        wr16(3'd1, 16'hFFFF);
        wr(3'd0, 8'h05);
        tick(1);
        expect_rd(3'd1, 8'h00, "R7 wrap lo");
        expect_rd(3'd2, 8'h00, "R7 wrap hi");
        expect_rd(3'd3, 8'h55, "R7 rld kept");
        expect_rd(3'd0, 8'h85, "R7 ovf flag");
        wr(3'd0, 8'h00);

        // R5 counter mode: falling edges only, tick_en ignored
        wr16(3'd1, 16'h0000);
        wr(3'd0, 8'h06);
        @(negedge clk); tick_en = 1'b1;
        cnt_pulse(); cnt_pulse(); cnt_pulse();
        @(negedge clk); tick_en = 1'b0;
        expect_rd(3'd1, 8'h03, "R5 three falls");
        expect_rd(3'd2, 8'h00, "R5 hi");
        wr(3'd0, 8'h00);

        // R8 trigger disabled
        wr16(3'd1, 16'h4321);
        wr(3'd0, 8'h01);
        trig_pulse();
        expect_rd(3'd3, 8'h55, "R8 rld lo kept");
        expect_rd(3'd4, 8'h55, "R8 rld hi kept");
        expect_rd(3'd0, 8'h01, "R8 no event flag");
        expect_item(1, 3'd0, 8'h00, "R8 irq low");

        // R9 capture trigger while stopped
        wr(3'd0, 8'h09);
        trig_pulse();
        expect_rd(3'd3, 8'h21, "R9 captured lo");
        expect_rd(3'd4, 8'h43, "R9 captured hi");
        expect_rd(3'd0, 8'h49, "R9 event flag");
        expect_item(1, 3'd0, 8'h01, "R9 irq");

        // R10 reload trigger
        wr(3'd0, 8'h08);
        wr16(3'd3, 16'h0777);
        wr16(3'd1, 16'h0100);
        trig_pulse();
        expect_rd(3'd1, 8'h77, "R10 loaded lo");
        expect_rd(3'd2, 8'h07, "R10 loaded hi");
        expect_rd(3'd0, 8'h48, "R10 event flag");

        // R12 clock-select outputs
        wr(3'd0, 8'h30);
        expect_rd(3'd0, 8'h30, "R12 stored");
        expect_item(2, 3'd0, 8'h03, "R12 both selects");
        wr(3'd0, 8'h20);
        expect_item(2, 3'd0, 8'h02, "R12 receive only");

        repeat (4) @(negedge clk);
        done = 1;
        summary();
    end
endmodule